// File: doc/BRIEF.md
# Programmable chip-select region decoder

This block maps an incoming 32-bit physical address onto one of eight chip-select regions. Each region has a configuration word that holds an enable flag, a base field counted in 16 MiB units, and a 4-bit size mask. The decode is combinational from the registered configuration words. It produces a one-hot chip-select vector, a hit flag, and the address relative to the start of the selected region.

A region whose base/mask pair cannot describe a naturally aligned window is treated as absent. The pair is illegal when the mask is not one of the four allowed codes, or when the base is not aligned to the region size. When windows overlap, the region with the lowest index is selected. A configuration write goes through a write mask. A one-cycle remap strobe for a region fires only when the write actually changed a stored bit. A write that repeats the stored value, or that differs only in discarded bits, leaves the mapping untouched and raises no strobe.

Top module: `cs_region_decoder`

## Requirements
- R1: After reset, the configuration word of region 0 reads 0x00000F40 (enabled, mask 0xF, base 0). Regions 1 to 7 read 0x00000F00 (disabled, mask 0xF, base 0).
- R2: A configuration write stores the written value ANDed with 0x00000F7F. The word is read back in this layout: base in bits 5:0, enable in bit 6, mask in bits 11:8, all other bits zero.
- R3: Only the mask codes 0x8, 0xC, 0xE and 0xF are legal. They give windows of 128, 64, 32 and 16 MiB. A region with any other mask code never hits.
- R4: A region whose base is not a multiple of its window size (base bits 3:0 set where the mask is clear) never hits.
- R5: A legal enabled region hits exactly for the addresses from base×16 MiB up to, but not including, base×16 MiB plus its window size.
- R6: A region with the enable bit clear never hits, whatever its base and mask.
- R7: The chip-select vector has at most one bit set: the lowest-indexed region that hits. The hit flag is high exactly when a bit is set.
- R8: On a hit, the offset output equals the address minus the start of the selected window. On a miss it is zero.
- R9: A configuration write changes the decode from the clock edge that stores it onward, and not in the cycle the write is presented.
- R10: The remap strobe of a region is high for exactly one cycle after a write that changed any bit under 0xF7F of its stored word. A write that changes no such bit raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wsel | input | 3 | Region index for the write |
| cfg_wdata | input | 32 | Configuration write value |
| cfg_rsel | input | 3 | Region index for the read-back |
| cfg_rdata | output | 32 | Stored configuration word of the region selected by cfg_rsel |
| addr | input | 32 | Address to decode |
| cs_sel | output | 8 | One-hot chip select of the winning region |
| cs_hit | output | 1 | High when some region claims the address |
| cs_offset | output | 32 | Address relative to the start of the winning region |
| remap_pulse | output | 8 | Per-region strobe, high for one cycle after a write that changed the mapping |

## Verification
A corrupted stored configuration word is visible on the read-back port in the same cycle. Within one decode it also moves, hides or duplicates a window: a 256-point sweep over every 16 MiB boundary, compared against window arithmetic, catches such a fault in the first sweep after it appears. A wrong legality or priority term changes the selected region or the offset at the boundary addresses of an overlapping or misaligned window. A wrong change detector either drops the strobe or raises it on a repeated write, and this shows on the cycle right after the write.

// File: rtl/csr_dec_pkg.sv
package csr_dec_pkg;

    localparam int BASE_W       = 6;
    localparam int MASK_W       = 4;
    localparam int REGION_SHIFT = 24;
    localparam int WORD_W       = 32;
    localparam logic [WORD_W-1:0] CFG_KEEP = 32'h0000_0F7F;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic              valid;
        logic [BASE_W-1:0] base;
    } region_cfg_t;

    function automatic region_cfg_t cfg_from_word(logic [WORD_W-1:0] w);
        region_cfg_t c;
        c.base  = w[BASE_W-1:0];
        c.valid = w[6];
        c.mask  = w[8 +: MASK_W];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] word_from_cfg(region_cfg_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[BASE_W-1:0]  = c.base;
        w[6]           = c.valid;
        w[8 +: MASK_W] = c.mask;
        return w;
    endfunction

    // only contiguous-from-top masks describe a power-of-two window
    function automatic logic mask_allowed(logic [MASK_W-1:0] m);
        logic ok;
        case (m)
            4'h8, 4'hC, 4'hE, 4'hF: ok = 1'b1;
            default:                ok = 1'b0;
        endcase
        return ok;
    endfunction

    // base width caps it below 0x40; alignment is checked on the low nibble
    function automatic logic pair_legal(logic [BASE_W-1:0] b, logic [MASK_W-1:0] m);
        return mask_allowed(m) && ((b[MASK_W-1:0] & ~m) == '0);
    endfunction

    function automatic region_cfg_t reset_cfg(int idx);
        region_cfg_t c;
        c.base  = '0;
        c.mask  = '1;
        c.valid = (idx == 0);
        return c;
    endfunction

endpackage

// File: rtl/csr_cfg_bank.sv
module csr_cfg_bank
    import csr_dec_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int IDX_W       = 3
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 we,
    input  logic [IDX_W-1:0]                     wsel,
    input  logic [WORD_W-1:0]                    wdata,
    input  logic [IDX_W-1:0]                     rsel,
    output logic [WORD_W-1:0]                    rdata,
    output region_cfg_t [NUM_REGIONS-1:0]        cfg,
    output logic [NUM_REGIONS-1:0]               pulse
);

    region_cfg_t incoming;
    assign incoming = cfg_from_word(wdata & CFG_KEEP);

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_reg
        region_cfg_t cfg_q;
        logic        pulse_q;
        logic        sel_here;

        assign sel_here = we && (wsel == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q   <= reset_cfg(g);
                pulse_q <= 1'b0;
            end else begin
                pulse_q <= 1'b0;
                if (sel_here) begin
                    cfg_q   <= incoming;
                    pulse_q <= (incoming != cfg_q);
                end
            end
        end

        assign cfg[g]   = cfg_q;
        assign pulse[g] = pulse_q;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (rsel == IDX_W'(i)) begin
                rdata = word_from_cfg(cfg[i]);
            end
        end
    end

endmodule

// File: rtl/csr_region_match.sv
module csr_region_match
    import csr_dec_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  region_cfg_t         cfg,
    input  logic [ADDR_W-1:0]   addr,
    output logic                hit,
    output logic [ADDR_W-1:0]   offset
);

    localparam int TOP_W = ADDR_W - REGION_SHIFT;

    logic [TOP_W-1:0] top;
    logic [TOP_W-1:0] base_ext;
    logic [TOP_W-1:0] cmp_mask;
    logic             legal;

    assign top      = addr[ADDR_W-1:REGION_SHIFT];
    assign base_ext = TOP_W'(cfg.base);
    assign cmp_mask = {{(TOP_W-MASK_W){1'b1}}, cfg.mask};
    assign legal    = pair_legal(cfg.base, cfg.mask);

    assign hit = cfg.valid && legal && (((top ^ base_ext) & cmp_mask) == '0);

    always_comb begin
        if (hit) begin
            offset = {top & ~cmp_mask, addr[REGION_SHIFT-1:0]};
        end else begin
            offset = '0;
        end
    end

endmodule

// File: rtl/csr_lowest_pick.sv
module csr_lowest_pick #(
    parameter int NUM_REGIONS = 8,
    parameter int ADDR_W      = 32
) (
    input  logic [NUM_REGIONS-1:0]             hits,
    input  logic [NUM_REGIONS-1:0][ADDR_W-1:0] offsets,
    output logic [NUM_REGIONS-1:0]             sel,
    output logic                               any,
    output logic [ADDR_W-1:0]                  offset
);

    // isolate the least significant set bit
    assign sel = hits & (~hits + NUM_REGIONS'(1));
    assign any = |hits;

    always_comb begin
        offset = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            offset = offset | (offsets[i] & {ADDR_W{sel[i]}});
        end
    end

endmodule

// File: rtl/cs_region_decoder.sv
module cs_region_decoder
    import csr_dec_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int ADDR_W      = 32,
    localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [IDX_W-1:0]        cfg_wsel,
    input  logic [WORD_W-1:0]       cfg_wdata,
    input  logic [IDX_W-1:0]        cfg_rsel,
    output logic [WORD_W-1:0]       cfg_rdata,
    input  logic [ADDR_W-1:0]       addr,
    output logic [NUM_REGIONS-1:0]  cs_sel,
    output logic                    cs_hit,
    output logic [ADDR_W-1:0]       cs_offset,
    output logic [NUM_REGIONS-1:0]  remap_pulse
);

    region_cfg_t [NUM_REGIONS-1:0]        cfg;
    logic [NUM_REGIONS-1:0]               hits;
    logic [NUM_REGIONS-1:0][ADDR_W-1:0]   offsets;

    csr_cfg_bank #(
        .NUM_REGIONS(NUM_REGIONS),
        .IDX_W      (IDX_W)
    ) u_bank (
        .clk  (clk),
        .rst  (rst),
        .we   (cfg_we),
        .wsel (cfg_wsel),
        .wdata(cfg_wdata),
        .rsel (cfg_rsel),
        .rdata(cfg_rdata),
        .cfg  (cfg),
        .pulse(remap_pulse)
    );

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
        csr_region_match #(
            .ADDR_W(ADDR_W)
        ) u_match (
            .cfg   (cfg[g]),
            .addr  (addr),
            .hit   (hits[g]),
            .offset(offsets[g])
        );
    end

    csr_lowest_pick #(
        .NUM_REGIONS(NUM_REGIONS),
        .ADDR_W     (ADDR_W)
    ) u_pick (
        .hits   (hits),
        .offsets(offsets),
        .sel    (cs_sel),
        .any    (cs_hit),
        .offset (cs_offset)
    );

endmodule

// File: rtl/csr_dec_checker.sv
module csr_dec_checker #(
    parameter int NUM_REGIONS = 8,
    parameter int ADDR_W      = 32
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   cfg_we,
    input logic [31:0]            cfg_rdata,
    input logic [NUM_REGIONS-1:0] cs_sel,
    input logic                   cs_hit,
    input logic [ADDR_W-1:0]      cs_offset,
    input logic [NUM_REGIONS-1:0] remap_pulse
);

    localparam int WIN_BITS = 27;

    // R7
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cs_sel));

    // R7
    hit_matches_sel_chk: assert property (@(posedge clk) disable iff (rst)
        cs_hit == (cs_sel != '0));

    // R8
    miss_offset_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_hit |-> (cs_offset == '0));

    // R8
    offset_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        cs_hit |-> (cs_offset[ADDR_W-1:WIN_BITS] == '0));

    // R10
    pulse_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        (remap_pulse != '0) |-> $past(cfg_we));

    // R10
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(remap_pulse));

    // R2
    rdata_layout_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata & ~32'h0000_0F7F) == '0);

endmodule

bind cs_region_decoder csr_dec_checker #(
    .NUM_REGIONS(NUM_REGIONS),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_rdata  (cfg_rdata),
    .cs_sel     (cs_sel),
    .cs_hit     (cs_hit),
    .cs_offset  (cs_offset),
    .remap_pulse(remap_pulse)
);

// File: tb/sim_cs_region_decoder.sv
`timescale 1ns/1ps
module sim_cs_region_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_wsel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [2:0]  cfg_rsel = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] addr = '0;
    logic [7:0]  cs_sel;
    logic        cs_hit;
    logic [31:0] cs_offset;
    logic [7:0]  remap_pulse;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [31:0] model [8];

    always #2.5 clk = ~clk;

    cs_region_decoder u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wsel(cfg_wsel),
        .cfg_wdata(cfg_wdata), .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata),
        .addr(addr), .cs_sel(cs_sel), .cs_hit(cs_hit), .cs_offset(cs_offset),
        .remap_pulse(remap_pulse)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // window arithmetic: start = base * 16 MiB, size from mask code
    task automatic expect_decode(input logic [31:0] a, output logic [7:0] sel,
                                 output logic hit, output logic [31:0] off);
        sel = '0; hit = 1'b0; off = '0;
        for (int i = 0; i < 8; i++) begin
            longint unsigned start, size;
            logic [31:0] w;
            w = model[i];
            start = longint'(w[5:0]) * 64'h100_0000;
            case (w[11:8])
                4'hF: size = 64'h100_0000;
                4'hE: size = 64'h200_0000;
                4'hC: size = 64'h400_0000;
                4'h8: size = 64'h800_0000;
                default: size = 0;
            endcase
            if (!hit && w[6] && size != 0 && (start % size) == 0 &&
                longint'(a) >= start && longint'(a) < start + size) begin
                hit = 1'b1;
                sel = 8'(1 << i);
                off = 32'(longint'(a) - start);
            end
        end
    endtask

    task automatic write_cfg(int idx, logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wsel = 3'(idx); cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
        model[idx] = val & 32'h0000_0F7F;
    endtask

    task automatic load_all(logic [31:0] w0, logic [31:0] w1, logic [31:0] w2,
                            logic [31:0] w3, logic [31:0] w4, logic [31:0] w5,
                            logic [31:0] w6, logic [31:0] w7);
        write_cfg(0, w0); write_cfg(1, w1); write_cfg(2, w2); write_cfg(3, w3);
        write_cfg(4, w4); write_cfg(5, w5); write_cfg(6, w6); write_cfg(7, w7);
    endtask

    // every 16 MiB boundary, with two low-bit patterns
    task automatic sweep(string tag);
        for (int t = 0; t < 256; t++) begin
            for (int p = 0; p < 2; p++) begin
                logic [7:0]  es;
                logic        eh;
                logic [31:0] eo;
                logic [23:0] lo;
                lo = (p == 0) ? 24'h0 : 24'(t * 24'h3B9AC7 + 24'hFFFFFF);
                @(negedge clk);
                addr = {8'(t), lo};
                #1;
                expect_decode(addr, es, eh, eo);
                check({tag, " R5 R7 R8 decode"}, {23'b0, cs_hit, cs_sel, cs_offset},
                      {23'b0, eh, es, eo});
            end
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) model[i] = (i == 0) ? 32'hF40 : 32'hF00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset read-back
        for (int i = 0; i < 8; i++) begin
            cfg_rsel = 3'(i);
            #1;
            check($sformatf("R1 reset word region %0d", i), 64'(cfg_rdata),
                  64'(model[i]));
        end
        check("R10 no strobe after reset", 64'(remap_pulse), 64'h0);
        sweep("R1 reset map");

        // R2: write mask and layout
        write_cfg(3, 32'hFFFF_FFFF);
        cfg_rsel = 3'd3; #1;
        check("R2 masked store", 64'(cfg_rdata), 64'h0000_0F7F);

        // R3 R5: each legal size, plus the top of the range
        load_all(32'h840, 32'hC48, 32'hE4C, 32'hF4E, 32'hF60, 32'hF7F, 32'hF00, 32'hF00);
        sweep("R3 R5 sizes");

        // R7: overlaps, lower index wins both ways
        load_all(32'h800, 32'hF00, 32'h840, 32'hF00, 32'hF51, 32'hF00, 32'hF43, 32'hE50);
        sweep("R7 overlap");

        // R3 R4 R6: illegal masks, misaligned bases, disabled regions
        load_all(32'hA40, 32'hC42, 32'hE01, 32'h050, 32'h8410, 32'hE43, 32'hF44, 32'h838);
        sweep("R3 R4 R6 reject");
        cfg_rsel = 3'd0; #1;
        check("R3 illegal mask still stored", 64'(cfg_rdata), 64'h0000_0A40);

        // R9: decode changes only after the storing edge
        @(negedge clk);
        addr = 32'h2100_0000;
        cfg_we = 1'b1; cfg_wsel = 3'd2; cfg_wdata = 32'h0000_0E60;
        #1;
        check("R9 decode before edge", {63'b0, cs_hit}, 64'h0);
        @(negedge clk);
        cfg_we = 1'b0;
        model[2] = 32'hE60;
        #1;
        check("R9 decode after edge", {23'b0, cs_hit, cs_sel, cs_offset},
              {23'b0, 1'b1, 8'h04, 32'h0100_0000});
        check("R10 strobe on change", 64'(remap_pulse), 64'h04);
        @(negedge clk);
        #1;
        check("R10 strobe lasts one cycle", 64'(remap_pulse), 64'h0);

        // R10: rewrite same value, then only discarded bits differ
        write_cfg(2, 32'h0000_0E60);
        #1;
        check("R10 same value no strobe", 64'(remap_pulse), 64'h0);
        write_cfg(2, 32'hABCD_F0E0 | 32'h0000_0E60);
        #1;
        check("R10 discarded bits no strobe", 64'(remap_pulse), 64'h0);
        cfg_rsel = 3'd2; #1;
        check("R2 discarded bits dropped", 64'(cfg_rdata), 64'h0000_0E60);
        write_cfg(7, 32'h0000_0838);
        #1;
        check("R10 unchanged region 7 no strobe", 64'(remap_pulse), 64'h0);
        write_cfg(7, 32'h0000_0878);
        #1;
        check("R10 enable toggle strobes", 64'(remap_pulse), 64'h80);
        sweep("R6 R10 final map");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule